// File: doc/BRIEF.md
# DDR SDRAM Bank-State Protocol Checker

This block watches the command bus between a DDR SDRAM controller and the memory. On each rising clock edge it captures the clock enable, the active-low chip-select, row-strobe, column-strobe and write-enable lines, the bank address and the auto-precharge select bit. It decodes the command, checks it against the present state of the addressed bank (or of the whole device), and moves a per-bank state machine forward. Several states are timed: row opening, precharging, data bursts and the device-wide lockouts after refresh, mode-register load and precharge-all. Each of these lasts a parameter-set number of cycles.

A command that breaks the rules raises a one-cycle flag in the cycle after it was sampled. The flag comes with a 3-bit reason code and the bank involved. A sticky copy of the first reason seen since reset is held until reset. A rejected command leaves every bank and the device unchanged, so one mistake does not set off a chain of follow-on errors. The block does not drive the bus. It is meant for simulation monitors and for on-chip protocol checking.

Top module: `ddr_bank_checker`

## Requirements
- R1: The strobes {cs_n, ras_n, cas_n, we_n} decode as follows. cs_n=1 is Deselect. 0111 is NOP, 0011 is Activate, 0101 is Read, 0100 is Write, 0010 is Precharge, 0110 is Burst Stop, 0001 is Refresh and 0000 is Mode Load. Deselect and NOP are legal in every state and change no bank state.
- R2: Activate is legal only on an Idle bank. The bank then ignores all same-bank commands (code 2) for T_RCD cycles and becomes Row Open on the following cycle.
- R3: Read is legal on a bank that is Row Open, Reading or Writing. Write is legal only on a bank that is Row Open or Writing. Any other case is rejected, with code 2 if the bank is busy and code 3 if it is not.
- R4: A single-bank Precharge (ap_bit=0) is legal on a bank that is Row Open, Reading or Writing. That bank is busy for T_RP cycles and then Idle. Precharge on an Idle bank is rejected with code 3.
- R5: A Read or Write with ap_bit=0 keeps its bank in the burst state for BURST_CYCLES cycles. The bank then returns to Row Open.
- R6: A Read or Write with ap_bit=1 makes its bank busy for BURST_CYCLES+T_RP cycles. The bank then returns to Idle.
- R7: While a bank is Activating, Precharging or in an auto-precharge burst, any command addressed to it is rejected with code 2. Commands to the other banks are judged on their own states.
- R8: Refresh and Mode Load need every bank to be Idle, otherwise they are rejected with code 4. After either one, every command other than Deselect or NOP is rejected with code 1, for T_RFC or T_MRD cycles respectively.
- R9: Precharge with ap_bit=1 (precharge all) is rejected with code 2 if any bank is busy. Otherwise every bank precharges, and all commands other than Deselect or NOP are rejected with code 1 for T_RP cycles.
- R10: Burst Stop acts on the bank of the most recent Read, whatever bank address is driven. It is legal only while that bank is still in its Read burst without auto-precharge, and it returns that bank to Row Open. Otherwise it is rejected with code 5, and the reported bank is that of the latest Read, or 0 if there has been no Read.
- R11: Commands are checked and acted on only when cke is high both in the current cycle and in the previous one. Otherwise nothing is flagged and no bank state changes.
- R12: A rejected command raises illegal_o for exactly the next cycle. err_code_o and err_bank_o then give the reason and the bank (the driven bank address, except for Burst Stop). A rejected command changes no state.
- R13: Synchronous reset makes every bank Idle and clears the lockout, illegal_o, err_code_o and sticky_code_o. sticky_code_o keeps the first nonzero reason code until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as seen by the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| ap_bit | input | 1 | Auto-precharge select; selects all banks for Precharge |
| illegal_o | output | 1 | One-cycle pulse for a rejected command |
| err_code_o | output | 3 | Reason code of the latest rejected command |
| err_bank_o | output | BA_W | Bank of the latest rejected command |
| sticky_code_o | output | 3 | First reason code since reset |

## Verification
The main sweep puts one bank in each of seven states (Idle, Activating, Row Open, Reading, Writing, auto-precharge Read, Precharging). It then applies every command, including precharge-all, and compares the flag, code and bank with a table computed in the bench. This separates busy from wrong-state rejections and bank-local rules from device-wide ones. A second sweep varies the cycle offset of a follow-up command across each timed window and one step past it, which shows whether every window is exactly its parameter long. Directed runs cover bank independence, Burst Stop across banks, clock-enable gating, the effect of a rejected command on state, and the sticky code.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

   typedef enum logic [3:0] {
      C_DESEL, C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_BT, C_REF, C_MRS
   } cmd_e;

   typedef enum logic [2:0] {
      B_IDLE, B_ACTIVATING, B_ROW_OPEN, B_READ, B_WRITE,
      B_RD_AP, B_WR_AP, B_PRECHARGING
   } bank_st_e;

   typedef enum logic [2:0] {
      OP_ACT, OP_RD, OP_WR, OP_RDA, OP_WRA, OP_PRE, OP_BT
   } bank_op_e;

   typedef enum logic [2:0] {
      E_NONE     = 3'd0,
      E_LOCKED   = 3'd1,
      E_BUSY     = 3'd2,
      E_STATE    = 3'd3,
      E_NOT_IDLE = 3'd4,
      E_NO_BURST = 3'd5
   } err_e;

   function automatic logic is_busy(bank_st_e s);
      return (s == B_ACTIVATING) || (s == B_RD_AP) ||
             (s == B_WR_AP) || (s == B_PRECHARGING);
   endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_chk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd_o
);

   always_comb begin
      if (cs_n) begin
         cmd_o = C_DESEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd_o = C_NOP;
            3'b011:  cmd_o = C_ACT;
            3'b101:  cmd_o = C_RD;
            3'b100:  cmd_o = C_WR;
            3'b010:  cmd_o = C_PRE;
            3'b110:  cmd_o = C_BT;
            3'b001:  cmd_o = C_REF;
            default: cmd_o = C_MRS;
         endcase
      end
   end

endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
   import ddr_chk_pkg::*;
#(
   parameter int T_RCD        = 2,
   parameter int T_RP         = 3,
   parameter int BURST_CYCLES = 4,
   parameter int CNT_W        = 4
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     go_i,
   input  bank_op_e op_i,
   output bank_st_e state_o
);

   localparam logic [CNT_W-1:0] RCD_LD   = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] RP_LD    = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] BURST_LD = CNT_W'(BURST_CYCLES - 1);

   bank_st_e         state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= B_IDLE;
         cnt_q   <= '0;
      end else if (go_i) begin
         case (op_i)
            OP_ACT: begin state_q <= B_ACTIVATING;  cnt_q <= RCD_LD;   end
            OP_RD:  begin state_q <= B_READ;        cnt_q <= BURST_LD; end
            OP_WR:  begin state_q <= B_WRITE;       cnt_q <= BURST_LD; end
            OP_RDA: begin state_q <= B_RD_AP;       cnt_q <= BURST_LD; end
            OP_WRA: begin state_q <= B_WR_AP;       cnt_q <= BURST_LD; end
            OP_PRE: begin state_q <= B_PRECHARGING; cnt_q <= RP_LD;    end
            default: begin state_q <= B_ROW_OPEN;   cnt_q <= '0;       end
         endcase
      end else begin
         case (state_q)
            B_ACTIVATING, B_READ, B_WRITE: begin
               if (cnt_q == '0) state_q <= B_ROW_OPEN;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            B_RD_AP, B_WR_AP: begin
               if (cnt_q == '0) begin
                  state_q <= B_PRECHARGING;
                  cnt_q   <= RP_LD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            B_PRECHARGING: begin
               if (cnt_q == '0) state_q <= B_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: cnt_q <= '0;
         endcase
      end
   end

   assign state_o = state_q;

   // R7
   busy_no_go_chk: assert property (@(posedge clk) disable iff (rst)
      go_i |-> !is_busy(state_q));

   // R2
   activating_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == B_ACTIVATING) |=>
         (state_q == B_ACTIVATING) || (state_q == B_ROW_OPEN));

   // R4
   precharge_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == B_PRECHARGING) |=>
         (state_q == B_PRECHARGING) || (state_q == B_IDLE));

   // R5
   burst_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == B_READ && !go_i) |=>
         (state_q == B_READ) || (state_q == B_ROW_OPEN));

endmodule

// File: rtl/ddr_dev_lock.sv
module ddr_dev_lock #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             busy_o
);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= load_i;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;

   // R8
   lock_retrig_chk: assert property (@(posedge clk) disable iff (rst)
      start_i |-> !busy_o);

   // R8
   lock_window_chk: assert property (@(posedge clk) disable iff (rst)
      start_i |=> busy_o);

endmodule

// File: rtl/ddr_bank_checker.sv
module ddr_bank_checker
   import ddr_chk_pkg::*;
#(
   parameter int NUM_BANKS    = 4,
   parameter int T_RCD        = 2,
   parameter int T_RP         = 3,
   parameter int T_RFC        = 8,
   parameter int T_MRD        = 2,
   parameter int BURST_CYCLES = 4,
   localparam int BA_W        = $clog2(NUM_BANKS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cke,
   input  logic            cs_n,
   input  logic            ras_n,
   input  logic            cas_n,
   input  logic            we_n,
   input  logic [BA_W-1:0] ba,
   input  logic            ap_bit,
   output logic            illegal_o,
   output logic [2:0]      err_code_o,
   output logic [BA_W-1:0] err_bank_o,
   output logic [2:0]      sticky_code_o
);

   localparam int MAX_A = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int MAX_B = (T_RFC > T_MRD) ? T_RFC : T_MRD;
   localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_T = (MAX_C > BURST_CYCLES) ? MAX_C : BURST_CYCLES;
   localparam int CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);
   localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 1);
   localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(T_MRD - 1);

   if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RFC < 1 || T_MRD < 1 || BURST_CYCLES < 1)
   begin : g_bad_timing
      $error("every timing parameter must be at least one cycle");
   end

   cmd_e                cmd;
   bank_st_e            st [NUM_BANKS];
   logic [NUM_BANKS-1:0] go;
   bank_op_e            op;
   logic                cke_prev_q;
   logic                checking;
   logic                lock_busy;
   logic                lock_start;
   logic [CNT_W-1:0]    lock_load;
   logic [BA_W-1:0]     rd_bank_q;
   logic                rd_seen_q;
   logic                all_idle;
   logic                any_busy;
   bank_st_e            tgt;
   err_e                err_d;
   logic [BA_W-1:0]     bank_d;
   logic                illegal_q;
   err_e                err_code_q;
   logic [BA_W-1:0]     err_bank_q;
   err_e                sticky_q;

   ddr_cmd_decode u_decode (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd_o (cmd)
   );

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      ddr_bank_fsm #(
         .T_RCD        (T_RCD),
         .T_RP         (T_RP),
         .BURST_CYCLES (BURST_CYCLES),
         .CNT_W        (CNT_W)
      ) u_bank (
         .clk     (clk),
         .rst     (rst),
         .go_i    (go[i]),
         .op_i    (op),
         .state_o (st[i])
      );
   end

   ddr_dev_lock #(.CNT_W(CNT_W)) u_lock (
      .clk     (clk),
      .rst     (rst),
      .start_i (lock_start),
      .load_i  (lock_load),
      .busy_o  (lock_busy)
   );

   assign checking = cke_prev_q & cke;
   assign tgt      = st[ba];

   always_comb begin
      all_idle = 1'b1;
      any_busy = 1'b0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (st[i] != B_IDLE) all_idle = 1'b0;
         if (is_busy(st[i]))  any_busy = 1'b1;
      end
   end

   always_comb begin
      err_d      = E_NONE;
      bank_d     = ba;
      go         = '0;
      op         = OP_ACT;
      lock_start = 1'b0;
      lock_load  = '0;
      if (checking && cmd != C_DESEL && cmd != C_NOP) begin
         if (lock_busy) begin
            err_d = E_LOCKED;
         end else begin
            case (cmd)
               C_ACT: begin
                  if (tgt == B_IDLE) begin
                     go[ba] = 1'b1;
                     op     = OP_ACT;
                  end else begin
                     err_d = is_busy(tgt) ? E_BUSY : E_STATE;
                  end
               end
               C_RD: begin
                  if (tgt == B_ROW_OPEN || tgt == B_READ || tgt == B_WRITE) begin
                     go[ba] = 1'b1;
                     op     = ap_bit ? OP_RDA : OP_RD;
                  end else begin
                     err_d = is_busy(tgt) ? E_BUSY : E_STATE;
                  end
               end
               C_WR: begin
                  if (tgt == B_ROW_OPEN || tgt == B_WRITE) begin
                     go[ba] = 1'b1;
                     op     = ap_bit ? OP_WRA : OP_WR;
                  end else begin
                     err_d = is_busy(tgt) ? E_BUSY : E_STATE;
                  end
               end
               C_PRE: begin
                  if (ap_bit) begin
                     if (any_busy) begin
                        err_d = E_BUSY;
                     end else begin
                        go         = '1;
                        op         = OP_PRE;
                        lock_start = 1'b1;
                        lock_load  = RP_LD;
                     end
                  end else if (tgt == B_ROW_OPEN || tgt == B_READ ||
                               tgt == B_WRITE) begin
                     go[ba] = 1'b1;
                     op     = OP_PRE;
                  end else begin
                     err_d = is_busy(tgt) ? E_BUSY : E_STATE;
                  end
               end
               C_BT: begin
                  bank_d = rd_seen_q ? rd_bank_q : '0;
                  if (rd_seen_q && st[rd_bank_q] == B_READ) begin
                     go[rd_bank_q] = 1'b1;
                     op            = OP_BT;
                  end else begin
                     err_d = E_NO_BURST;
                  end
               end
               C_REF, C_MRS: begin
                  if (all_idle) begin
                     lock_start = 1'b1;
                     lock_load  = (cmd == C_REF) ? RFC_LD : MRD_LD;
                  end else begin
                     err_d = E_NOT_IDLE;
                  end
               end
               default: err_d = E_NONE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cke_prev_q <= 1'b0;
         rd_bank_q  <= '0;
         rd_seen_q  <= 1'b0;
         illegal_q  <= 1'b0;
         err_code_q <= E_NONE;
         err_bank_q <= '0;
         sticky_q   <= E_NONE;
      end else begin
         cke_prev_q <= cke;
         if (go != '0 && (op == OP_RD || op == OP_RDA)) begin
            rd_bank_q <= ba;
            rd_seen_q <= 1'b1;
         end
         illegal_q <= (err_d != E_NONE);
         if (err_d != E_NONE) begin
            err_code_q <= err_d;
            err_bank_q <= bank_d;
            if (sticky_q == E_NONE) sticky_q <= err_d;
         end
      end
   end

   assign illegal_o     = illegal_q;
   assign err_code_o    = err_code_q;
   assign err_bank_o    = err_bank_q;
   assign sticky_code_o = sticky_q;

   // R11
   cke_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !cke |=> !illegal_o);

   // R13
   sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sticky_code_o != 3'd0) |=> $stable(sticky_code_o));

   // R12
   reject_no_go_chk: assert property (@(posedge clk) disable iff (rst)
      (err_d != E_NONE) |-> (go == '0 && !lock_start));

   // R9
   lock_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      lock_busy |-> (go == '0));

endmodule

// File: tb/tb_ddr_bank_checker.sv
module tb_ddr_bank_checker;

   localparam int CLK_PERIOD = 10;
   localparam int TRCD  = 2;
   localparam int TRP   = 3;
   localparam int TRFC  = 5;
   localparam int TMRD  = 2;
   localparam int BURST = 4;

   localparam int K_DES = 0, K_NOP = 1, K_ACT = 2, K_RD = 3, K_WR = 4;
   localparam int K_PRE = 5, K_BT = 6, K_REF = 7, K_MRS = 8, K_PREA = 9;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cke = 1'b1;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic       ap_bit = 1'b0;
   logic       illegal_o;
   logic [2:0] err_code_o;
   logic [1:0] err_bank_o;
   logic [2:0] sticky_code_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ddr_bank_checker #(
      .NUM_BANKS (4), .T_RCD (TRCD), .T_RP (TRP), .T_RFC (TRFC),
      .T_MRD (TMRD), .BURST_CYCLES (BURST)
   ) dut (
      .clk (clk), .rst (rst), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
      .cas_n (cas_n), .we_n (we_n), .ba (ba), .ap_bit (ap_bit),
      .illegal_o (illegal_o), .err_code_o (err_code_o),
      .err_bank_o (err_bank_o), .sticky_code_o (sticky_code_o)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic drive(input int c, input logic [1:0] b, input logic ap);
      logic [3:0] s;
      case (c)
         K_DES:        s = 4'b1111;
         K_ACT:        s = 4'b0011;
         K_RD:         s = 4'b0101;
         K_WR:         s = 4'b0100;
         K_PRE, K_PREA: s = 4'b0010;
         K_BT:         s = 4'b0110;
         K_REF:        s = 4'b0001;
         K_MRS:        s = 4'b0000;
         default:      s = 4'b0111;
      endcase
      {cs_n, ras_n, cas_n, we_n} = s;
      ba     = b;
      ap_bit = (c == K_PREA) ? 1'b1 : ap;
      @(negedge clk);
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) drive(K_NOP, 2'd0, 1'b0);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      cke = 1'b1;
      nop(3);
      rst = 1'b0;
      nop(2);
   endtask

   task automatic expect_out(input string req, input int e, input int eb);
      check(req, int'(illegal_o), (e != 0) ? 1 : 0);
      if (e != 0) begin
         check(req, int'(err_code_o), e);
         check(req, int'(err_bank_o), eb);
      end
   endtask

   // setup states: 0 idle, 1 activating, 2 row open, 3 read, 4 write,
   // 5 read with auto-precharge, 6 precharging
   task automatic setup(input int s, input logic [1:0] b);
      do_reset();
      if (s != 0) drive(K_ACT, b, 1'b0);
      if (s >= 2) nop(TRCD);
      case (s)
         3: drive(K_RD, b, 1'b0);
         4: drive(K_WR, b, 1'b0);
         5: drive(K_RD, b, 1'b1);
         6: drive(K_PRE, b, 1'b0);
         default: ;
      endcase
   endtask

   function automatic int model_code(input int s, input int c);
      bit busy;
      busy = (s == 1) || (s == 5) || (s == 6);
      case (c)
         K_ACT:  return (s == 0) ? 0 : (busy ? 2 : 3);
         K_RD:   return (s == 2 || s == 3 || s == 4) ? 0 : (busy ? 2 : 3);
         K_WR:   return (s == 2 || s == 4) ? 0 : (busy ? 2 : 3);
         K_PRE:  return (s == 2 || s == 3 || s == 4) ? 0 : (busy ? 2 : 3);
         K_BT:   return (s == 3) ? 0 : 5;
         K_REF, K_MRS: return (s == 0) ? 0 : 4;
         K_PREA: return busy ? 2 : 0;
         default: return 0;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R13 reset state
      check("R13 reset illegal", int'(illegal_o), 0);
      check("R13 reset sticky", int'(sticky_code_o), 0);
      check("R13 reset code", int'(err_code_o), 0);

      // R1 R2 R3 R4 R7 R8 R9 R10: state x command sweep on bank 2
      for (int s = 0; s < 7; s++) begin
         for (int c = 0; c < 10; c++) begin
            int eb;
            setup(s, 2'd2);
            drive(c, 2'd2, 1'b0);
            eb = (c == K_BT) ? ((s == 3 || s == 5) ? 2 : 0) : 2;
            expect_out($sformatf("R1/R3/R7 sweep s%0d c%0d", s, c),
                       model_code(s, c), eb);
         end
         // R7 other bank judged on its own state
         setup(s, 2'd2);
         drive(K_ACT, 2'd3, 1'b0);
         expect_out($sformatf("R7 other bank s%0d", s), 0, 3);
      end

      // R2 activation window
      for (int off = 1; off <= TRCD + 2; off++) begin
         setup(1, 2'd0);
         nop(off - 1);
         drive(K_RD, 2'd0, 1'b0);
         expect_out($sformatf("R2 trcd off%0d", off), (off <= TRCD) ? 2 : 0, 0);
      end
      // R4 precharge window
      for (int off = 1; off <= TRP + 2; off++) begin
         setup(6, 2'd1);
         nop(off - 1);
         drive(K_ACT, 2'd1, 1'b0);
         expect_out($sformatf("R4 trp off%0d", off), (off <= TRP) ? 2 : 0, 1);
      end
      // R5 burst length
      for (int off = 1; off <= BURST + 2; off++) begin
         setup(3, 2'd0);
         nop(off - 1);
         drive(K_BT, 2'd3, 1'b0);
         expect_out($sformatf("R5 burst off%0d", off), (off <= BURST) ? 0 : 5, 0);
      end
      for (int off = 1; off <= BURST + 2; off++) begin
         setup(3, 2'd0);
         nop(off - 1);
         drive(K_WR, 2'd0, 1'b0);
         expect_out($sformatf("R5 wr after rd off%0d", off), (off <= BURST) ? 3 : 0, 0);
      end
      // R6 auto-precharge window
      for (int off = 1; off <= BURST + TRP + 2; off++) begin
         setup(5, 2'd3);
         nop(off - 1);
         drive(K_ACT, 2'd3, 1'b0);
         expect_out($sformatf("R6 ap off%0d", off), (off <= BURST + TRP) ? 2 : 0, 3);
      end
      // R8 refresh and mode-load lockouts
      for (int off = 1; off <= TRFC + 2; off++) begin
         do_reset();
         drive(K_REF, 2'd0, 1'b0);
         nop(off - 1);
         drive(K_ACT, 2'd1, 1'b0);
         expect_out($sformatf("R8 trfc off%0d", off), (off <= TRFC) ? 1 : 0, 1);
      end
      for (int off = 1; off <= TMRD + 2; off++) begin
         do_reset();
         drive(K_MRS, 2'd0, 1'b0);
         nop(off - 1);
         drive(K_ACT, 2'd2, 1'b0);
         expect_out($sformatf("R8 tmrd off%0d", off), (off <= TMRD) ? 1 : 0, 2);
      end
      // R9 precharge-all lockout
      for (int off = 1; off <= TRP + 2; off++) begin
         setup(2, 2'd0);
         drive(K_PREA, 2'd0, 1'b1);
         nop(off - 1);
         drive(K_ACT, 2'd2, 1'b0);
         expect_out($sformatf("R9 prea off%0d", off), (off <= TRP) ? 1 : 0, 2);
      end

      // R10 burst stop targets most recent read bank
      do_reset();
      drive(K_ACT, 2'd0, 1'b0);
      drive(K_ACT, 2'd1, 1'b0);
      nop(TRCD);
      drive(K_RD, 2'd0, 1'b0);
      drive(K_RD, 2'd1, 1'b0);
      drive(K_BT, 2'd0, 1'b0);
      expect_out("R10 stop legal", 0, 0);
      drive(K_WR, 2'd1, 1'b0);
      expect_out("R10 stopped bank open", 0, 1);
      drive(K_WR, 2'd0, 1'b0);
      expect_out("R10 other bank still reading", 3, 0);

      // R11 clock-enable gating
      setup(2, 2'd0);
      cke = 1'b0;
      drive(K_ACT, 2'd0, 1'b0);
      expect_out("R11 cke low", 0, 0);
      cke = 1'b1;
      drive(K_ACT, 2'd0, 1'b0);
      expect_out("R11 cke rising", 0, 0);
      drive(K_RD, 2'd0, 1'b0);
      expect_out("R11 no state change", 0, 0);
      drive(K_ACT, 2'd0, 1'b0);
      expect_out("R11 checking resumed", 3, 0);

      // R12 rejected command leaves state and flag pulses once
      setup(2, 2'd1);
      drive(K_ACT, 2'd1, 1'b0);
      expect_out("R12 reject", 3, 1);
      drive(K_RD, 2'd1, 1'b0);
      expect_out("R12 state kept", 0, 1);

      // R13 sticky holds first reason
      do_reset();
      drive(K_RD, 2'd1, 1'b0);
      expect_out("R13 first error", 3, 1);
      drive(K_BT, 2'd2, 1'b0);
      expect_out("R13 second error", 5, 0);
      check("R13 sticky first", int'(sticky_code_o), 3);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule